// File: doc/BRIEF.md
# Tooth Sensor Mode Sequencer

This block decides, cycle by cycle, which operating mode a tooth-sensing signal chain is in and what the digital sensor output may do in that mode. After reset, and again after any undervoltage event, it drives the sensor output high and waits for a fixed offset-calibration interval. It then enters a start phase. In the start phase it watches the incoming sample stream until the signal has swung far enough to be trusted, and it records whether that swing was crossed on the high side or on the low side. That side selects which threshold the downstream comparator arms first.

In running mode the sensor output follows the comparator's requested level on each accepted sample. When the peak-to-peak amplitude reported by the peak detector falls into the vibration range, the block enters a lockout mode. Lockout freezes the output, and the block leaves lockout only when the amplitude climbs past a second, higher level. The threshold arithmetic itself is outside this block. The block takes the comparator's requested level `cmp_lvl` and the measured amplitude `amp_pp` as inputs.

Samples arrive on a valid/ready stream. A sample is taken in a cycle where `s_valid` and `s_ready` are both high. `s_ready` depends only on the mode and never on `s_valid`. `s_ready` is low in the reset and calibration modes, so an upstream source must hold its sample and `cmp_lvl` until the sample is accepted. The mode, amplitude, undervoltage and output pins are plain level signals.

Top module: `tooth_mode_seq`

## Requirements
- R1: While `uv_flag` is high, or during reset, the next state is mode RESET (code 0) with `sens_out` = 1 and `sw_en` = 0. When `uv_flag` is low, RESET moves to CAL (code 1) on the next clock.
- R2: `s_ready` and `pk_upd_en` are 0 in RESET and CAL and 1 in START, RUN and LOCKOUT. A sample presented with `s_valid` = 0 has no effect.
- R3: CAL lasts exactly `CAL_CYCLES` clock cycles and is then followed by START (code 2).
- R4: In START, `sens_out` stays 1 whatever `cmp_lvl` is. The block stays in START until an accepted sample lies more than `HYST` above the lowest, or more than `HYST` below the highest, earlier sample accepted in this START. It then enters RUN (code 3).
- R5: `init_thr_sel` is set to 1 when the START exit was taken on the high side (sample above the running minimum by more than `HYST`). It is set to 0 when the exit was taken on the low side. It then holds through RUN and LOCKOUT.
- R6: In RUN with `amp_pp` >= `LOE_LVL`, each accepted sample copies `cmp_lvl` into `sens_out`. Because the output is high on entry, a first sample with `cmp_lvl` = 1 causes no change and the first edge is high to low.
- R7: In RUN, `amp_pp` < `LOE_LVL` moves the block to LOCKOUT (code 4) with `sw_en` = 0. `amp_pp` equal to `LOE_LVL` keeps it in RUN.
- R8: In LOCKOUT, `sens_out` holds its value whatever the accepted samples are. The block returns to RUN only when `amp_pp` > `LOR_LVL`, and `amp_pp` equal to `LOR_LVL` keeps it locked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| uv_flag | input | 1 | Supply undervoltage indication |
| s_valid | input | 1 | Sample stream valid |
| s_ready | output | 1 | Sample stream ready |
| s_data | input | DW | Signed differential sample |
| cmp_lvl | input | 1 | Comparator's requested output level, carried with the sample |
| amp_pp | input | AW | Measured peak-to-peak amplitude, unsigned |
| mode | output | 3 | Current mode code (0 RESET, 1 CAL, 2 START, 3 RUN, 4 LOCKOUT) |
| sw_en | output | 1 | Output switching enabled (RUN) |
| pk_upd_en | output | 1 | Peak trackers may update |
| init_thr_sel | output | 1 | First armed threshold: 1 operate, 0 release |
| sens_out | output | 1 | Digital sensor output |

## Verification
A wrong mode register shows on `mode`, `s_ready` and `sw_en` at the very next sample point. A calibration counter that is off by one moves the START entry by a cycle, and the exact-count check catches that move. A fault in the start-phase min/max tracker shows up as a wrong `init_thr_sel`, or as an early or late RUN entry, on the sample that should have ended START. A lockout that holds the wrong value shows as a `sens_out` change within one accepted sample.

// File: rtl/tms_pkg.sv
package tms_pkg;
  typedef enum logic [2:0] {
    MD_RESET = 3'd0,
    MD_CAL   = 3'd1,
    MD_START = 3'd2,
    MD_RUN   = 3'd3,
    MD_LOCK  = 3'd4
  } mode_t;
endpackage

// File: rtl/tms_cal_timer.sv
module tms_cal_timer #(
  parameter int CAL_CYCLES = 100000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic done
);
  localparam int CW = $clog2(CAL_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(CAL_CYCLES - 1);

  logic [CW-1:0] cnt;

  assign done = en && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (!en)     cnt <= '0;
    else if (!done)   cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/tms_start_gate.sv
module tms_start_gate #(
  parameter int DW   = 12,
  parameter int HYST = 40
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic                 take,
  input  logic signed [DW-1:0] data,
  output logic                 pass,
  output logic                 high_side
);
  localparam logic signed [DW:0] HYST_W = (DW+1)'(HYST);

  logic                 have;
  logic signed [DW-1:0] lo_pk, hi_pk;
  logic signed [DW:0]   rise, fall;
  logic                 hi_hit, lo_hit;

  always_comb begin
    rise   = (DW+1)'(data) - (DW+1)'(lo_pk);
    fall   = (DW+1)'(hi_pk) - (DW+1)'(data);
    hi_hit = have && (rise > HYST_W);
    lo_hit = have && !hi_hit && (fall > HYST_W);
  end

  assign pass      = take && (hi_hit || lo_hit);
  assign high_side = hi_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have  <= 1'b0;
      lo_pk <= '0;
      hi_pk <= '0;
    end else if (!en) begin
      have  <= 1'b0;
    end else if (take) begin
      have <= 1'b1;
      if (!have || data < lo_pk) lo_pk <= data;
      if (!have || data > hi_pk) hi_pk <= data;
    end
  end
endmodule

// File: rtl/tms_amp_window.sv
module tms_amp_window #(
  parameter int AW      = 12,
  parameter int LOE_LVL = 100,
  parameter int LOR_LVL = 220
) (
  input  logic [AW-1:0] amp,
  output logic          below_loe,
  output logic          above_lor
);
  localparam logic [AW-1:0] LOE_W = AW'(LOE_LVL);
  localparam logic [AW-1:0] LOR_W = AW'(LOR_LVL);

  generate
    if (LOE_LVL >= LOR_LVL) begin : g_bad_levels
      $error("lockout enable level must be below release level");
    end
  endgenerate

  assign below_loe = amp < LOE_W;
  assign above_lor = amp > LOR_W;
endmodule

// File: rtl/tooth_mode_seq.sv
module tooth_mode_seq #(
  parameter int DW         = 12,
  parameter int AW         = 12,
  parameter int CAL_CYCLES = 100000,
  parameter int HYST       = 40,
  parameter int LOE_LVL    = 100,
  parameter int LOR_LVL    = 220
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 uv_flag,
  input  logic                 s_valid,
  output logic                 s_ready,
  input  logic signed [DW-1:0] s_data,
  input  logic                 cmp_lvl,
  input  logic [AW-1:0]        amp_pp,
  output logic [2:0]           mode,
  output logic                 sw_en,
  output logic                 pk_upd_en,
  output logic                 init_thr_sel,
  output logic                 sens_out
);
  import tms_pkg::*;

  mode_t st, st_nx;
  logic  cal_done, gate_pass, gate_high, below_loe, above_lor, fire;

  assign s_ready   = (st == MD_START) || (st == MD_RUN) || (st == MD_LOCK);
  assign pk_upd_en = s_ready;
  assign sw_en     = (st == MD_RUN);
  assign mode      = st;
  assign fire      = s_valid && s_ready;

  tms_cal_timer #(.CAL_CYCLES(CAL_CYCLES)) u_cal (
    .clk(clk), .rst_n(rst_n), .en(st == MD_CAL), .done(cal_done)
  );

  tms_start_gate #(.DW(DW), .HYST(HYST)) u_gate (
    .clk(clk), .rst_n(rst_n), .en(st == MD_START),
    .take(fire && (st == MD_START)), .data(s_data),
    .pass(gate_pass), .high_side(gate_high)
  );

  tms_amp_window #(.AW(AW), .LOE_LVL(LOE_LVL), .LOR_LVL(LOR_LVL)) u_win (
    .amp(amp_pp), .below_loe(below_loe), .above_lor(above_lor)
  );

  always_comb begin
    st_nx = st;
    if (uv_flag) st_nx = MD_RESET;
    else begin
      case (st)
        MD_RESET: st_nx = MD_CAL;
        MD_CAL:   if (cal_done)  st_nx = MD_START;
        MD_START: if (gate_pass) st_nx = MD_RUN;
        MD_RUN:   if (below_loe) st_nx = MD_LOCK;
        MD_LOCK:  if (above_lor) st_nx = MD_RUN;
        default:  st_nx = MD_RESET;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st           <= MD_RESET;
      sens_out     <= 1'b1;
      init_thr_sel <= 1'b0;
    end else begin
      st <= st_nx;
      if (uv_flag || st == MD_RESET) begin
        sens_out     <= 1'b1;
        init_thr_sel <= 1'b0;
      end else if (st == MD_CAL) begin
        sens_out <= 1'b1;
      end else if (st == MD_START) begin
        sens_out <= 1'b1;
        if (gate_pass) init_thr_sel <= gate_high;
      end else if (st == MD_RUN && fire && !below_loe) begin
        sens_out <= cmp_lvl;
      end
    end
  end

  // R1: undervoltage forces reset mode and a high output
  a_r1_uv_forces_pos: assert property (@(posedge clk) disable iff (!rst_n)
    uv_flag |=> (st == MD_RESET) && sens_out);

  // R4: output held high before running mode
  a_r4_high_before_run: assert property (@(posedge clk) disable iff (!rst_n)
    (st == MD_RESET || st == MD_CAL || st == MD_START) |=> sens_out);

  // R5: start-side selection is frozen once running
  a_r5_thr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == MD_RUN || st == MD_LOCK) && !uv_flag) |=> $stable(init_thr_sel));

  // R7: small amplitude in running mode enters lockout
  a_r7_lock_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (st == MD_RUN && below_loe && !uv_flag) |=> (st == MD_LOCK));

  // R8: lockout holds the output and stays until release level is passed
  a_r8_lock_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (st == MD_LOCK && !uv_flag) |=> $stable(sens_out));

  a_r8_lock_stay: assert property (@(posedge clk) disable iff (!rst_n)
    (st == MD_LOCK && !above_lor && !uv_flag) |=> (st == MD_LOCK));
endmodule

// File: tb/sim_tooth_mode_seq.sv
`timescale 1ns/1ps
module sim_tooth_mode_seq;
  localparam int DW = 12, AW = 12, NCAL = 16, HYS = 40, LOE = 100, LOR = 220;

  logic clk = 0;
  logic rst_n = 0;
  logic uv_flag = 0;
  logic s_valid = 0;
  logic signed [DW-1:0] s_data = '0;
  logic cmp_lvl = 1;
  logic [AW-1:0] amp_pp = '0;
  logic s_ready, sw_en, pk_upd_en, init_thr_sel, sens_out;
  logic [2:0] mode;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  tooth_mode_seq #(.DW(DW), .AW(AW), .CAL_CYCLES(NCAL), .HYST(HYS),
                   .LOE_LVL(LOE), .LOR_LVL(LOR)) u0 (
    .clk(clk), .rst_n(rst_n), .uv_flag(uv_flag), .s_valid(s_valid),
    .s_ready(s_ready), .s_data(s_data), .cmp_lvl(cmp_lvl), .amp_pp(amp_pp),
    .mode(mode), .sw_en(sw_en), .pk_upd_en(pk_upd_en),
    .init_thr_sel(init_thr_sel), .sens_out(sens_out));

  task automatic chk(input string tag, input int act, input int expv);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, act, expv);
    end
  endtask

  // one accepted sample; returns at the next falling edge
  task automatic push(input int d, input logic lvl);
    s_data = DW'(d); cmp_lvl = lvl; s_valid = 1;
    @(negedge clk);
    s_valid = 0;
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk("R1 mode in reset", mode, 0);
    chk("R1 out high in reset", sens_out, 1);
    chk("R1 sw_en in reset", sw_en, 0);
    chk("R2 ready in reset", s_ready, 0);
    rst_n = 1;
  endtask

  task automatic t_cal;
    @(negedge clk);
    chk("R1 reset to cal", mode, 1);
    chk("R2 ready low in cal", s_ready, 0);
    chk("R2 peak update low in cal", pk_upd_en, 0);
    repeat (NCAL - 1) @(negedge clk);
    chk("R3 still cal at N-1", mode, 1);
    @(negedge clk);
    chk("R3 start after N", mode, 2);
    chk("R2 ready in start", s_ready, 1);
    chk("R2 peak update in start", pk_upd_en, 1);
  endtask

  task automatic t_start_low;
    amp_pp = 300;
    push(0, 0); push(20, 0); push(-15, 0);
    chk("R4 no exit under hyst", mode, 2);
    chk("R4 out high in start", sens_out, 1);
    s_data = -200; s_valid = 0; @(negedge clk);
    chk("R2 invalid sample ignored", mode, 2);
    push(-30, 1);
    chk("R4 exit to run", mode, 3);
    chk("R5 low side selects release", init_thr_sel, 0);
    chk("R6 out high entering run", sens_out, 1);
    chk("R7 sw_en in run", sw_en, 1);
  endtask

  task automatic t_run;
    push(-60, 1);
    chk("R6 release while high no change", sens_out, 1);
    push(60, 0);
    chk("R6 first edge high to low", sens_out, 0);
    push(-60, 1);
    chk("R6 follow high", sens_out, 1);
    amp_pp = LOE;
    push(60, 0);
    chk("R7 amp at LOE stays run", mode, 3);
    chk("R6 follow low", sens_out, 0);
  endtask

  task automatic t_lock;
    amp_pp = 80;
    @(negedge clk);
    chk("R7 enter lockout", mode, 4);
    chk("R7 sw_en off in lockout", sw_en, 0);
    push(-60, 1);
    chk("R8 out held in lockout", sens_out, 0);
    amp_pp = 150;
    push(-60, 1);
    chk("R8 mid amplitude stays locked", mode, 4);
    amp_pp = LOR;
    push(-60, 1);
    chk("R8 amp at LOR stays locked", mode, 4);
    chk("R8 out still held", sens_out, 0);
    amp_pp = 250;
    @(negedge clk);
    chk("R8 release to run", mode, 3);
    push(-60, 1);
    chk("R8 recovery switching", sens_out, 1);
    push(60, 0);
    chk("R8 recovery low", sens_out, 0);
  endtask

  task automatic t_uv;
    uv_flag = 1;
    @(negedge clk);
    chk("R1 uv to reset", mode, 0);
    chk("R1 uv forces out high", sens_out, 1);
    chk("R1 uv clears sw_en", sw_en, 0);
    uv_flag = 0;
    @(negedge clk);
    chk("R1 uv recovery to cal", mode, 1);
    repeat (NCAL) @(negedge clk);
    chk("R3 start after uv cal", mode, 2);
  endtask

  task automatic t_start_high;
    push(0, 0); push(30, 0);
    chk("R4 still start", mode, 2);
    chk("R4 out high despite low request", sens_out, 1);
    push(45, 0);
    chk("R4 high side exit", mode, 3);
    chk("R5 high side selects operate", init_thr_sel, 1);
    push(60, 0);
    chk("R6 first edge after high side", sens_out, 0);
    amp_pp = 10;
    @(negedge clk);
    chk("R5 selection kept in lockout", init_thr_sel, 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      fails++;
      $display("FAIL watchdog: got %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_cal();
    t_start_low();
    t_run();
    t_lock();
    t_uv();
    t_start_high();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule